// File: doc/BRIEF.md
# Dual-Channel Test Pattern Injector

This block sits between the two 16-bit conversion channels (A and B) and the serializer that ships their words off-chip. While its enable is clear, it passes the real samples through. While the enable is set, it swaps them for a synthetic pattern, so that the link can be checked against known data. Three pattern kinds are available: a fixed word per channel taken from two constant registers, a ramp with a coarse programmable step, and a checkerboard word that flips on every readout.

The outputs are registered and move only on the readout strobe, which marks the moment the serializer takes a new word pair. The ramp and the checkerboard share one rule. Their state advances on every enabled readout, whichever pattern is selected, and goes back to its starting point whenever the enable is cleared. Re-enabling therefore always starts from a known word.

Top module: `testpat_mux`

## Requirements
- R1: After a synchronous active-high reset, both outputs are 0x0000, the ramp restarts from 0 and the checkerboard restarts from 0xAAAA.
- R2: The outputs change only at a clock edge where `rd_stb` is high. At every other edge they hold, even when data, constants or controls change.
- R3: With `pat_en` low at a strobe edge, `out_a` takes `smp_a` and `out_b` takes `smp_b`.
- R4: With `pat_en` high and `pat_mode` = 2'b00, `out_a` takes `const_a` and `out_b` takes `const_b`.
- R5: With `pat_mode` = 2'b01, both outputs carry the ramp value. The first enabled readout gives 0, and each enabled readout then adds the step.
- R6: The ramp step comes from `ramp_step` as (code+1)×1024: 2'b00=1024, 2'b01=2048, 2'b10=3072, 2'b11=4096. The ramp wraps modulo 2^16.
- R7: With `pat_mode` = 2'b10, both outputs carry the same word. It is 0xAAAA on the first enabled readout and then alternates with 0x5555 on each readout.
- R8: With `pat_mode` = 2'b11, the code is reserved and both outputs are 0x0000.
- R9: The ramp and checkerboard state advance on every enabled readout in any mode. Both return to their start values while `pat_en` is low.
- R10: `pat_en` and `pat_mode` are taken in the same cycle as the strobe. A strobe in the cycle in which the enable rises already yields the first pattern word, and a strobe in the cycle in which it falls yields the samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_a | input | 16 | Conversion sample, channel A |
| smp_b | input | 16 | Conversion sample, channel B |
| rd_stb | input | 1 | Readout strobe, one cycle per word pair |
| pat_en | input | 1 | Pattern enable |
| pat_mode | input | 2 | Pattern select: 00 constant, 01 ramp, 10 checkerboard, 11 reserved |
| ramp_step | input | 2 | Ramp step code |
| const_a | input | 16 | Constant word for channel A |
| const_b | input | 16 | Constant word for channel B |
| out_a | output | 16 | Word to serializer, channel A |
| out_b | output | 16 | Word to serializer, channel B |

## Verification
Two events can fall in the same cycle: a readout strobe, and a change of the enable, which also clears the ramp and checkerboard state. The bench raises `pat_en` in the very cycle that carries the strobe and expects the first checkerboard word 0xAAAA on that readout. It then drops the enable together with a strobe and expects the raw samples. A third case checks that state is shared across modes. Two checkerboard readouts are followed by a ramp readout, which must show two steps already taken, and a later checkerboard readout must show the phase left by three toggles.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    PM_CONST = 2'b00,
    PM_RAMP  = 2'b01,
    PM_CHECK = 2'b10,
    PM_RSVD  = 2'b11
  } pat_mode_e;
endpackage

// File: rtl/tpg_ramp.sv
module tpg_ramp #(
  parameter int DATA_W     = 16,
  parameter int CODE_W     = 2,
  parameter int STEP_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              adv,
  input  logic [CODE_W-1:0] step_code,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] step_units;
  logic [DATA_W-1:0] step;

  assign step_units = DATA_W'(step_code) + DATA_W'(1);
  assign step       = step_units << STEP_SHIFT;

  always_ff @(posedge clk) begin
    if (rst || !en) value <= '0;
    else if (adv)   value <= value + step;
  end

  assert_ramp_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> value == '0);
  assert_ramp_advance_R6: assert property (@(posedge clk) disable iff (rst)
    (en && adv) |=> value == DATA_W'($past(value) + (DATA_W'($past(step_code)) + DATA_W'(1)) * (1 << STEP_SHIFT)));
  assert_ramp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (en && !adv) |=> $stable(value));
endmodule

// File: rtl/tpg_check.sv
module tpg_check #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              adv,
  output logic [DATA_W-1:0] word
);
  logic              phase;
  logic [DATA_W-1:0] odd_word;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bits
    localparam logic BITV = (i % 2) == 1;
    assign odd_word[i] = BITV;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) phase <= 1'b0;
    else if (adv)   phase <= ~phase;
  end

  assign word = phase ? ~odd_word : odd_word;

  assert_check_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    (en && adv) |=> word == ~$past(word));
  assert_check_restart_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> word == odd_word);
endmodule

// File: rtl/tpg_select.sv
module tpg_select
  import tpg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] smp_a,
  input  logic [DATA_W-1:0] smp_b,
  input  logic [DATA_W-1:0] const_a,
  input  logic [DATA_W-1:0] const_b,
  input  logic [DATA_W-1:0] ramp,
  input  logic [DATA_W-1:0] check,
  output logic [DATA_W-1:0] nxt_a,
  output logic [DATA_W-1:0] nxt_b
);
  pat_mode_e sel;
  assign sel = pat_mode_e'(mode);

  always_comb begin
    nxt_a = smp_a;
    nxt_b = smp_b;
    if (en) begin
      case (sel)
        PM_CONST: begin nxt_a = const_a; nxt_b = const_b; end
        PM_RAMP:  begin nxt_a = ramp;    nxt_b = ramp;    end
        PM_CHECK: begin nxt_a = check;   nxt_b = check;   end
        default:  begin nxt_a = '0;      nxt_b = '0;      end
      endcase
    end
  end
endmodule

// File: rtl/testpat_mux.sv
module testpat_mux #(
  parameter int DATA_W     = 16,
  parameter int CODE_W     = 2,
  parameter int STEP_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] smp_a,
  input  logic [DATA_W-1:0] smp_b,
  input  logic              rd_stb,
  input  logic              pat_en,
  input  logic [1:0]        pat_mode,
  input  logic [CODE_W-1:0] ramp_step,
  input  logic [DATA_W-1:0] const_a,
  input  logic [DATA_W-1:0] const_b,
  output logic [DATA_W-1:0] out_a,
  output logic [DATA_W-1:0] out_b
);
  logic [DATA_W-1:0] ramp_val;
  logic [DATA_W-1:0] check_val;
  logic [DATA_W-1:0] nxt_a;
  logic [DATA_W-1:0] nxt_b;

  tpg_ramp #(.DATA_W(DATA_W), .CODE_W(CODE_W), .STEP_SHIFT(STEP_SHIFT)) u_ramp (
    .clk(clk), .rst(rst), .en(pat_en), .adv(rd_stb),
    .step_code(ramp_step), .value(ramp_val)
  );

  tpg_check #(.DATA_W(DATA_W)) u_check (
    .clk(clk), .rst(rst), .en(pat_en), .adv(rd_stb), .word(check_val)
  );

  tpg_select #(.DATA_W(DATA_W)) u_sel (
    .en(pat_en), .mode(pat_mode), .smp_a(smp_a), .smp_b(smp_b),
    .const_a(const_a), .const_b(const_b), .ramp(ramp_val), .check(check_val),
    .nxt_a(nxt_a), .nxt_b(nxt_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a <= '0;
      out_b <= '0;
    end else if (rd_stb) begin
      out_a <= nxt_a;
      out_b <= nxt_b;
    end
  end

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(out_a) && $stable(out_b));
  assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !pat_en) |=> out_a == $past(smp_a) && out_b == $past(smp_b));
  assert_const_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && pat_en && pat_mode == 2'b00) |=> out_a == $past(const_a) && out_b == $past(const_b));
  assert_check_pair_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && pat_en && pat_mode == 2'b10) |=> out_a == out_b && $countones(out_a) == DATA_W / 2);
  assert_reserved_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && pat_en && pat_mode == 2'b11) |=> out_a == '0 && out_b == '0);
endmodule

// File: tb/test_testpat_mux.sv
`timescale 1ns/1ps
module test_testpat_mux;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] smp_a = '0, smp_b = '0, const_a = '0, const_b = '0;
  logic        rd_stb = 1'b0, pat_en = 1'b0;
  logic [1:0]  pat_mode = 2'b00, ramp_step = 2'b00;
  logic [15:0] out_a, out_b;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  testpat_mux i_testpat_mux (
    .clk(clk), .rst(rst), .smp_a(smp_a), .smp_b(smp_b), .rd_stb(rd_stb),
    .pat_en(pat_en), .pat_mode(pat_mode), .ramp_step(ramp_step),
    .const_a(const_a), .const_b(const_b), .out_a(out_a), .out_b(out_b)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic en, input logic [1:0] mode, input logic [1:0] code);
    @(negedge clk);
    pat_en = en; pat_mode = mode; ramp_step = code;
  endtask

  task automatic strobe();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 out_a", out_a, 16'h0000);
    chk("R1 out_b", out_b, 16'h0000);
  endtask

  task automatic t_bypass();
    cfg(1'b0, 2'b00, 2'b00);
    smp_a = 16'h1234; smp_b = 16'hFEDC;
    strobe();
    chk("R3 out_a", out_a, 16'h1234);
    chk("R3 out_b", out_b, 16'hFEDC);
  endtask

  task automatic t_hold();
    smp_a = 16'h0F0F; smp_b = 16'hF0F0;
    repeat (3) @(negedge clk);
    chk("R2 hold a", out_a, 16'h1234);
    chk("R2 hold b", out_b, 16'hFEDC);
    cfg(1'b1, 2'b00, 2'b00);
    const_a = 16'hBEEF; const_b = 16'hCAFE;
    repeat (2) @(negedge clk);
    chk("R2 hold after mode a", out_a, 16'h1234);
  endtask

  task automatic t_const();
    cfg(1'b1, 2'b00, 2'b00);
    const_a = 16'h0123; const_b = 16'h89AB;
    strobe();
    chk("R4 out_a", out_a, 16'h0123);
    chk("R4 out_b", out_b, 16'h89AB);
  endtask

  task automatic t_ramp();
    cfg(1'b0, 2'b01, 2'b00);
    cfg(1'b1, 2'b01, 2'b00);
    for (int k = 0; k < 3; k++) begin
      strobe();
      chk("R5 ramp a", out_a, 16'(k * 1024));
      chk("R5 ramp b", out_b, 16'(k * 1024));
    end
    cfg(1'b1, 2'b01, 2'b10);
    strobe(); chk("R6 step 3072 first", out_a, 16'd3072);
    strobe(); chk("R6 step 3072 second", out_a, 16'd6144);
    cfg(1'b1, 2'b01, 2'b01);
    strobe(); chk("R6 step 2048", out_a, 16'd9216);
    strobe(); chk("R6 step 2048 next", out_a, 16'd11264);
  endtask

  task automatic t_wrap();
    cfg(1'b0, 2'b01, 2'b11);
    cfg(1'b1, 2'b01, 2'b11);
    for (int k = 0; k < 16; k++) begin
      strobe();
      chk("R6 step 4096", out_a, 16'(k * 4096));
    end
    strobe();
    chk("R6 wrap", out_a, 16'h0000);
  endtask

  task automatic t_check();
    cfg(1'b0, 2'b10, 2'b00);
    cfg(1'b1, 2'b10, 2'b00);
    strobe(); chk("R7 first a", out_a, 16'hAAAA); chk("R7 first b", out_b, 16'hAAAA);
    strobe(); chk("R7 second a", out_a, 16'h5555); chk("R7 second b", out_b, 16'h5555);
    strobe(); chk("R7 third", out_a, 16'hAAAA);
  endtask

  task automatic t_reserved();
    cfg(1'b1, 2'b11, 2'b00);
    smp_a = 16'h7777; smp_b = 16'h8888;
    strobe();
    chk("R8 out_a", out_a, 16'h0000);
    chk("R8 out_b", out_b, 16'h0000);
  endtask

  task automatic t_shared_state();
    cfg(1'b0, 2'b10, 2'b00);
    cfg(1'b1, 2'b10, 2'b00);
    strobe(); strobe();
    chk("R9 check before switch", out_a, 16'h5555);
    cfg(1'b1, 2'b01, 2'b00);
    strobe();
    chk("R9 ramp advanced in other mode", out_a, 16'd2048);
    cfg(1'b1, 2'b10, 2'b00);
    strobe();
    chk("R9 check phase kept", out_a, 16'h5555);
    cfg(1'b0, 2'b01, 2'b00);
    cfg(1'b1, 2'b01, 2'b00);
    strobe();
    chk("R9 ramp restarts", out_a, 16'h0000);
  endtask

  task automatic t_same_cycle();
    cfg(1'b0, 2'b10, 2'b00);
    smp_a = 16'h4321; smp_b = 16'h1357;
    @(negedge clk);
    pat_en = 1'b1; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk("R10 enable with strobe", out_a, 16'hAAAA);
    @(negedge clk);
    pat_en = 1'b0; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk("R10 disable with strobe a", out_a, 16'h4321);
    chk("R10 disable with strobe b", out_b, 16'h1357);
  endtask

  task automatic t_reset_mid();
    cfg(1'b1, 2'b01, 2'b00);
    strobe(); strobe();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 mid-run reset", out_a, 16'h0000);
    strobe();
    chk("R1 ramp from zero", out_a, 16'h0000);
    cfg(1'b1, 2'b10, 2'b00);
    strobe();
    chk("R1 check phase after reset", out_a, 16'h5555);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, 100000);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_bypass();
    t_hold();
    t_const();
    t_ramp();
    t_wrap();
    t_check();
    t_reserved();
    t_shared_state();
    t_same_cycle();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule